// File: doc/BRIEF.md
# In-Order Retire Control Buffer

This block keeps track of instructions that have been dispatched into an out-of-order backend and not yet retired. Each dispatched instruction reserves a run of consecutive entries in a circular slot buffer, one entry per micro-op. The block hands back a token, which is the slot where that run starts. Later, the execution pipeline reports completion by quoting the token. The block then marks the instruction as executed.

On every clock the block looks at the oldest live token. Starting there, it retires executed instructions in program order, up to a configurable number per clock. It frees their slots and reports each retired instruction's index to the dispatch logic on a set of notification lanes. Dispatch logic uses the full, empty and availability outputs to decide whether the next instruction fits.

Top module: `rob_retire_ctl`

## Requirements
- R1: After reset the buffer is empty, not full, the error flag is low, no lane reports a retirement, and the first accepted reservation gets token 0.
- R2: A reservation is accepted (`disp_ok` high) exactly when `disp_valid` is high and the free count is at least the needed slot count. The token returned is the current tail position. On acceptance the tail advances by the needed count modulo `DEPTH`, wrapping from the last slot back to slot 0.
- R3: The needed slot count is the micro-op count, capped at `DEPTH`. A count of 0 is taken as 1. The same rule applies to reservations and to the availability query.
- R4: `chk_ok` is high exactly when the free count is at least the needed slot count of `chk_qty`.
- R5: `full` is high when no slot is free. `empty` is high when all `DEPTH` slots are free.
- R6: A completion whose `cmpl_id` equals the start slot of a live token marks that token executed. Retirement runs in program order and stops at the first token that has not executed, even when younger tokens have already executed.
- R7: At most `MAX_RETIRE` instructions retire per clock, where 0 means no limit. Retirements fill lanes from lane 0 upward, oldest instruction first.
- R8: Each retired instruction's index appears on its lane while `ret_valid` for that lane is high. Slots freed by a retirement count as free only from the following cycle.
- R9: A completion for an ID that is not the start of a live token changes no token. It sets `err`, which then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Reservation request |
| disp_idx | input | IDX_W | Instruction index of the request |
| disp_uops | input | UOP_W | Micro-op count of the request |
| disp_ok | output | 1 | Request accepted this cycle |
| disp_token | output | PTR_W | Token (start slot) given to an accepted request |
| chk_qty | input | UOP_W | Quantity for the availability query |
| chk_ok | output | 1 | Enough free slots for `chk_qty` |
| cmpl_valid | input | 1 | Execution-complete strobe |
| cmpl_id | input | PTR_W | Token of the completed instruction |
| ret_valid | output | LANES | Per-lane retirement strobe, lane 0 oldest |
| ret_idx | output | LANES*IDX_W | Per-lane retired instruction index |
| full | output | 1 | No free slot |
| empty | output | 1 | All slots free |
| err | output | 1 | Sticky flag for a completion with an unknown ID |

## Verification
Some properties are checked by the embedded assertions on every cycle:
- a reservation never lands on a live slot;
- a full buffer never accepts;
- an empty buffer never retires;
- retirement lanes stay packed from lane 0;
- a retired start slot is no longer live afterwards;
- the free count stays in range;
- the error flag is set by a bad completion and then never clears.

Other behaviours only the scenarios can show:
- program order across out-of-order completions, through a scoreboard of dispatched indices;
- the two-per-clock retire cap;
- the one-cycle delay before freed slots count;
- capping of oversized and zero counts;
- tail wrap-around.

// File: rtl/rob_retire_ctl.sv
module rob_retire_ctl #(
  parameter int DEPTH      = 8,
  parameter int IDX_W      = 8,
  parameter int UOP_W      = 4,
  parameter int MAX_RETIRE = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int LANES = (MAX_RETIRE == 0 || MAX_RETIRE > DEPTH) ? DEPTH : MAX_RETIRE
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   disp_valid,
  input  logic [IDX_W-1:0]       disp_idx,
  input  logic [UOP_W-1:0]       disp_uops,
  output logic                   disp_ok,
  output logic [PTR_W-1:0]       disp_token,
  input  logic [UOP_W-1:0]       chk_qty,
  output logic                   chk_ok,
  input  logic                   cmpl_valid,
  input  logic [PTR_W-1:0]       cmpl_id,
  output logic [LANES-1:0]       ret_valid,
  output logic [LANES*IDX_W-1:0] ret_idx,
  output logic                   full,
  output logic                   empty,
  output logic                   err
);

  function automatic logic [CNT_W-1:0] cap(input logic [UOP_W-1:0] q);
    int unsigned v;
    v = int'(q);
    if (v == 0) v = 1;
    if (v > DEPTH) v = DEPTH;
    return CNT_W'(v);
  endfunction

  function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p, input logic [CNT_W-1:0] n);
    int unsigned s;
    s = int'(p) + int'(n);
    if (s >= DEPTH) s = s - DEPTH;
    return PTR_W'(s);
  endfunction

  logic [IDX_W-1:0] idx_q [DEPTH];
  logic [CNT_W-1:0] len_q [DEPTH];
  logic [DEPTH-1:0] live_q, exe_q;
  logic [PTR_W-1:0] head_q, tail_q, head_d;
  logic [CNT_W-1:0] free_q, need, freed;
  logic [DEPTH-1:0] clr, set_m, done_m;
  logic             cmpl_hit;

  assign need       = cap(disp_uops);
  assign disp_ok    = disp_valid && (free_q >= need);
  assign disp_token = tail_q;
  assign chk_ok     = free_q >= cap(chk_qty);
  assign full       = free_q == '0;
  assign empty      = free_q == CNT_W'(DEPTH);
  assign cmpl_hit   = cmpl_valid && live_q[cmpl_id];
  assign set_m      = disp_ok  ? (DEPTH'(1) << tail_q)  : '0;
  assign done_m     = cmpl_hit ? (DEPTH'(1) << cmpl_id) : '0;

  always_comb begin
    logic [PTR_W-1:0] p;
    int               rem, got;
    logic             go;
    p = head_q;
    rem = DEPTH - int'(free_q);
    got = 0;
    go = 1'b1;
    clr = '0;
    ret_valid = '0;
    ret_idx = '0;
    for (int l = 0; l < LANES; l++) begin
      if (go && rem > 0 && live_q[p] && exe_q[p]) begin
        ret_valid[l] = 1'b1;
        ret_idx[l*IDX_W +: IDX_W] = idx_q[p];
        clr[p] = 1'b1;
        got = got + int'(len_q[p]);
        rem = rem - int'(len_q[p]);
        p = adv(p, len_q[p]);
      end else begin
        go = 1'b0;
      end
    end
    head_d = p;
    freed = CNT_W'(got);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      free_q <= CNT_W'(DEPTH);
      live_q <= '0;
      exe_q  <= '0;
      err    <= 1'b0;
    end else begin
      head_q <= head_d;
      live_q <= (live_q & ~clr) | set_m;
      exe_q  <= ((exe_q & ~clr) | done_m) & ~set_m;
      free_q <= free_q - (disp_ok ? need : '0) + freed;
      if (disp_ok) tail_q <= adv(tail_q, need);
      if (cmpl_valid && !live_q[cmpl_id]) err <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (disp_ok) begin
      idx_q[tail_q] <= disp_idx;
      len_q[tail_q] <= need;
    end
  end

  AST_TAIL_SLOT_FREE: assert property (@(posedge clk) disable iff (!rst_n) disp_ok |-> !live_q[tail_q]); // R2
  AST_FULL_REJECTS: assert property (@(posedge clk) disable iff (!rst_n) full |-> !disp_ok); // R2
  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n) free_q <= CNT_W'(DEPTH)); // R5
  AST_EMPTY_NO_RETIRE: assert property (@(posedge clk) disable iff (!rst_n) empty |-> !ret_valid[0]); // R6
  AST_RETIRED_SLOT_DEAD: assert property (@(posedge clk) disable iff (!rst_n) ret_valid[0] |=> !live_q[$past(head_q)]); // R8
  AST_BAD_CMPL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) (cmpl_valid && !live_q[cmpl_id]) |=> err); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) err |=> err); // R9

  for (genvar l = 1; l < LANES; l++) begin : g_lane_chk
    AST_LANES_PACKED: assert property (@(posedge clk) disable iff (!rst_n) ret_valid[l] |-> ret_valid[l-1]); // R7
  end

endmodule

// File: tb/rob_retire_ctl_test.sv
`timescale 1ns/1ps
module rob_retire_ctl_test;
  localparam int LANES = 2;
  logic clk = 0, rst_n = 0;
  logic disp_valid = 0, cmpl_valid = 0;
  logic [7:0] disp_idx = 0;
  logic [3:0] disp_uops = 0, chk_qty = 1;
  logic [2:0] cmpl_id = 0;
  logic disp_ok, chk_ok, full, empty, err;
  logic [2:0] disp_token;
  logic [LANES-1:0] ret_valid;
  logic [LANES*8-1:0] ret_idx;
  int errors = 0, checks = 0;
  logic [7:0] expq [$];
  bit done = 0;

  rob_retire_ctl uut (.clk, .rst_n, .disp_valid, .disp_idx, .disp_uops, .disp_ok, .disp_token,
    .chk_qty, .chk_ok, .cmpl_valid, .cmpl_id, .ret_valid, .ret_idx, .full, .empty, .err);

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n)
    for (int l = 0; l < LANES; l++) if (ret_valid[l]) begin
      if (expq.size() == 0) check(0, "R6 unexpected retire", ret_idx[l*8 +: 8], -1);
      else begin
        automatic logic [7:0] e = expq.pop_front();
        check(ret_idx[l*8 +: 8] == e, "R8 retired index order", ret_idx[l*8 +: 8], e);
      end
    end

  task automatic dispatch(input logic [7:0] idx, input logic [3:0] u, input bit exp_ok, input int exp_tok);
    @(negedge clk);
    disp_valid = 1; disp_idx = idx; disp_uops = u;
    #1;
    check(disp_ok == exp_ok, "R2 accept", disp_ok, exp_ok);
    if (exp_ok) begin
      check(disp_token == exp_tok, "R2 token", disp_token, exp_tok);
      expq.push_back(idx);
    end
    @(posedge clk); #1 disp_valid = 0;
  endtask

  task automatic complete(input logic [2:0] id);
    @(negedge clk);
    cmpl_valid = 1; cmpl_id = id;
    @(posedge clk); #1 cmpl_valid = 0;
  endtask

  task automatic query(input logic [3:0] q, input bit exp, input string req);
    chk_qty = q; #0.5;
    check(chk_ok == exp, req, chk_ok, exp);
  endtask

  task automatic wait_empty();
    for (int i = 0; i < 20 && !empty; i++) @(negedge clk);
    #1 check(empty == 1, "R5 drained to empty", empty, 1);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;
    check(empty == 1, "R1 empty after reset", empty, 1);
    check(full == 0, "R1 not full after reset", full, 0);
    check(err == 0, "R1 err clear", err, 0);
    check(ret_valid == 0, "R1 no retire", ret_valid, 0);
    query(8, 1, "R4 whole buffer free");

    dispatch(8'd10, 3, 1, 0);   // R1 first token is 0
    dispatch(8'd11, 2, 1, 3);
    dispatch(8'd12, 1, 1, 5);
    @(negedge clk); #1;
    query(2, 1, "R4 two free");
    query(3, 0, "R4 three not free");
    dispatch(8'd99, 3, 0, 0);   // R2 rejected, not enough room

    complete(3'd3);
    complete(3'd5);
    @(negedge clk); #1;
    check(ret_valid == 0, "R6 younger executed, head not", ret_valid, 0);
    complete(3'd0);
    @(negedge clk); #1;
    check(ret_valid == 2'b11, "R7 two retire in one clock", ret_valid, 3);
    query(3, 0, "R8 freed slots not yet usable");
    @(negedge clk); #1;
    check(ret_valid == 2'b01, "R7 remainder next clock", ret_valid, 1);
    query(7, 1, "R8 freed slots visible next cycle");
    query(8, 0, "R8 last token still held");
    @(negedge clk); #1;
    check(empty == 1, "R5 empty after all retire", empty, 1);

    query(15, 1, "R3 oversized query capped");
    dispatch(8'd20, 15, 1, 6);  // R3 capped to whole buffer
    @(negedge clk); #1;
    check(full == 1, "R5 full", full, 1);
    check(empty == 0, "R5 not empty", empty, 0);
    dispatch(8'd21, 1, 0, 0);
    complete(3'd6);
    wait_empty();

    dispatch(8'd30, 0, 1, 6);   // R3 zero counts as one
    dispatch(8'd31, 1, 1, 7);
    dispatch(8'd32, 2, 1, 0);   // R2 wrap to slot 0
    @(negedge clk); #1;
    query(4, 1, "R3 zero took one slot");
    query(5, 0, "R3 zero took one slot");

    complete(3'd1);             // R9 interior slot, not a token start
    @(negedge clk); #1;
    check(err == 1, "R9 err set", err, 1);
    check(ret_valid == 0, "R9 bad completion ignored", ret_valid, 0);
    complete(3'd7);
    complete(3'd6);
    @(negedge clk); #1;
    query(4, 1, "R9 slot 0 token not completed by bad id");
    complete(3'd0);
    wait_empty();
    check(err == 1, "R9 err sticky", err, 1);
    check(expq.size() == 0, "R8 all dispatched retired", expq.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule